// File: doc/BRIEF.md
# Indirect PCI Configuration Register Window

This block holds the first 64 bytes of a type-0 PCI configuration header and gives a host two ways to reach it. On the local bus the host writes an address register, then reads or writes a data window. The low two bits of the data-window address are the starting byte inside the selected configuration dword. A second, PCI-side port reaches the same bytes a whole dword at a time with byte enables. Its write rights are narrower.

Each configuration byte falls into one of four classes: writable from both ports, writable only from the local bus, read-only with a fixed reset value, or unimplemented. Unimplemented bytes always read zero. Both ports return read data one cycle after the request. When both ports write the same byte in the same cycle, the local-bus write is the one that lands.

Top module: `pci_cfg_window`

## Requirements
- R1: After reset the address register reads 0x00000000 and neither read-valid output is high. The vendor ID reads 0xA5C3, the device ID 0x0B17, the revision ID 0x02, the class code 0x068000, the interrupt pin 0x01 and the minimum grant 0x04. Every other byte reads zero.
- R2: `lb_addr_i[2]`=0 selects the address register. Any write to it stores enable (bit 31), bus (23:16), device (15:11), function (10:8) and register number (7:2). A read of it returns those fields, with bits 30:24 and 1:0 reading zero. Size and byte offset are ignored for the address register.
- R3: The window is closed when enable is 0 or when bus, device or function is nonzero. A data-window read (`lb_addr_i[2]`=1) while the window is closed returns 0xFFFFFFFF, and a data-window write while it is closed changes nothing.
- R4: `lb_size_i` selects the access size: 0 is a byte, 1 is a halfword, and 2 or 3 is a word. The byte offset is `lb_addr_i[1:0]`. Data is right-justified: data byte k maps to configuration byte 4·reg+offset+k. Bytes that would fall past the end of the dword are dropped on writes and read as zero.
- R5: The local bus can write offsets 0x00–0x0B, 0x0D, 0x14–0x1B, 0x2C–0x2F and 0x3C.
- R6: The PCI port can write only offsets 0x04–0x08, 0x0D, 0x14–0x1B and 0x3C. Its writes to vendor, device, class and subsystem IDs are ignored.
- R7: Offsets 0x0C, 0x0E, 0x0F, 0x10–0x13, 0x34, 0x3D and 0x3E keep their reset values regardless of writes from either port.
- R8: All other offsets, and every register number of 16 or above, read as zero, and writes to them are discarded.
- R9: The PCI port addresses a dword by `pci_reg_i`. `pci_be_i[k]` enables byte lane k at bits 8k+7:8k, and only enabled, PCI-writable bytes change.
- R10: If both ports write the same byte in one cycle, the local-bus value is stored. Writes from the two ports to different bytes in the same cycle both take effect.
- R11: Each read request raises that port's read-valid output, with its data, exactly one cycle later. Read-valid stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lb_req_i | input | 1 | Local-bus access request |
| lb_we_i | input | 1 | Local-bus write when high |
| lb_addr_i | input | 3 | Bit 2 selects the data window; bits 1:0 are the byte offset |
| lb_size_i | input | 2 | Access size (0 byte, 1 half, 2/3 word) |
| lb_wdata_i | input | 32 | Local-bus write data, right-justified |
| lb_rvalid_o | output | 1 | Local-bus read data valid |
| lb_rdata_o | output | 32 | Local-bus read data |
| pci_req_i | input | 1 | PCI-side configuration request |
| pci_we_i | input | 1 | PCI-side write when high |
| pci_reg_i | input | 6 | PCI-side dword register number |
| pci_be_i | input | 4 | PCI-side byte enables |
| pci_wdata_i | input | 32 | PCI-side write data, natural lanes |
| pci_rvalid_o | output | 1 | PCI-side read data valid |
| pci_rdata_o | output | 32 | PCI-side read data |

## Verification
Writes to the address register or to configuration bytes take effect at the next rising edge, so any read issued in a later cycle sees the new state. Read data and read-valid are due exactly one rising edge after the request. The driver presents every request at a falling edge and queues its expected value. The monitor compares at the following falling edge, one cycle later. Valid data arriving with nothing expected, or an expected item that never arrives, is reported against R11.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned BW = 8;
  localparam int unsigned LANES = DW / BW;
  localparam int unsigned REG_NO_W = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic                en;
    logic [7:0]          bus;
    logic [4:0]          dev;
    logic [2:0]          fn;
    logic [REG_NO_W-1:0] reg_no;
  } cfg_addr_t;

  function automatic bit lb_wr_ok(int unsigned a);
    return (a <= 32'h0B) || (a == 32'h0D) || (a >= 32'h14 && a <= 32'h1B) ||
           (a >= 32'h2C && a <= 32'h2F) || (a == 32'h3C);
  endfunction

  function automatic bit pci_wr_ok(int unsigned a);
    return (a >= 32'h04 && a <= 32'h08) || (a == 32'h0D) ||
           (a >= 32'h14 && a <= 32'h1B) || (a == 32'h3C);
  endfunction

  function automatic bit ro_byte(int unsigned a);
    return (a == 32'h0C) || (a == 32'h0E) || (a == 32'h0F) ||
           (a >= 32'h10 && a <= 32'h13) || (a == 32'h34) ||
           (a == 32'h3D) || (a == 32'h3E);
  endfunction
endpackage

// File: rtl/pci_cfg_addr_reg.sv
module pci_cfg_addr_reg
  import pci_cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  cfg_addr_t wval_i,
  output cfg_addr_t addr_o,
  output logic [DW-1:0] rdata_o,
  output logic      open_o
);
  cfg_addr_t addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (we_i) addr_q <= wval_i;
  end

  assign addr_o  = addr_q;
  assign rdata_o = {addr_q.en, 7'b0, addr_q.bus, addr_q.dev, addr_q.fn, addr_q.reg_no, 2'b00};
  assign open_o  = addr_q.en && (addr_q.bus == '0) && (addr_q.dev == '0) && (addr_q.fn == '0);
endmodule

// File: rtl/pci_cfg_lane.sv
module pci_cfg_lane
  import pci_cfg_pkg::*;
(
  input  logic [1:0]       off_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    dword_i,
  output logic [LANES-1:0] be_o,
  output logic [DW-1:0]    wlane_o,
  output logic [DW-1:0]    rdata_o
);
  logic [LANES-1:0] base_be;
  logic [DW-1:0]    shifted;
  logic [4:0]       shamt;

  assign shamt = {off_i, 3'b000};

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: base_be = 4'b0001;
      SZ_HALF: base_be = 4'b0011;
      default: base_be = 4'b1111;
    endcase
  end

  assign be_o    = base_be << off_i;
  assign wlane_o = wdata_i << shamt;
  assign shifted = dword_i >> shamt;

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: rdata_o = {24'b0, shifted[7:0]};
      SZ_HALF: rdata_o = {16'b0, shifted[15:0]};
      default: rdata_o = shifted;
    endcase
  end
endmodule

// File: rtl/pci_cfg_store.sv
module pci_cfg_store
  import pci_cfg_pkg::*;
#(
  parameter int unsigned NREG       = 16,
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID  = 16'h0B17,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h068000,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h04,
  localparam int unsigned NBYTE = NREG * LANES,
  localparam int unsigned IDXW  = $clog2(NREG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NBYTE-1:0]    lb_be_i,
  input  logic [DW-1:0]       lb_wdata_i,
  input  logic [NBYTE-1:0]    pci_be_i,
  input  logic [DW-1:0]       pci_wdata_i,
  input  logic [REG_NO_W-1:0] lb_idx_i,
  input  logic [REG_NO_W-1:0] pci_idx_i,
  output logic [DW-1:0]       lb_dword_o,
  output logic [DW-1:0]       pci_dword_o
);
  function automatic logic [7:0] rst_val(int unsigned a);
    case (a)
      0:       return VENDOR_ID[7:0];
      1:       return VENDOR_ID[15:8];
      2:       return DEVICE_ID[7:0];
      3:       return DEVICE_ID[15:8];
      8:       return REV_ID;
      9:       return CLASS_CODE[7:0];
      10:      return CLASS_CODE[15:8];
      11:      return CLASS_CODE[23:16];
      61:      return INT_PIN;
      62:      return MIN_GNT;
      default: return 8'h00;
    endcase
  endfunction

  logic [DW-1:0] dw [NREG];

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    localparam bit          LBW = lb_wr_ok(b);
    localparam bit          PW  = pci_wr_ok(b);
    localparam bit          RO  = ro_byte(b);
    localparam logic [7:0]  RV  = rst_val(b);
    localparam int unsigned LN  = b % LANES;
    logic [7:0] q;
    if (LBW) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                q <= RV;
        else if (lb_be_i[b])        q <= lb_wdata_i[BW*LN +: BW];  // local wins
        else if (PW && pci_be_i[b]) q <= pci_wdata_i[BW*LN +: BW];
      end
    end else if (RO) begin : g_ro
      assign q = RV;
    end else begin : g_none
      assign q = 8'h00;
    end
    assign dw[b / LANES][BW*LN +: BW] = q;
  end

  assign lb_dword_o  = (lb_idx_i  < REG_NO_W'(NREG)) ? dw[lb_idx_i[IDXW-1:0]]  : '0;
  assign pci_dword_o = (pci_idx_i < REG_NO_W'(NREG)) ? dw[pci_idx_i[IDXW-1:0]] : '0;
endmodule

// File: rtl/pci_cfg_window.sv
module pci_cfg_window
  import pci_cfg_pkg::*;
#(
  parameter int unsigned NREG       = 16,
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID  = 16'h0B17,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h068000,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h04,
  localparam int unsigned NBYTE = NREG * LANES
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lb_req_i,
  input  logic        lb_we_i,
  input  logic [2:0]  lb_addr_i,
  input  logic [1:0]  lb_size_i,
  input  logic [31:0] lb_wdata_i,
  output logic        lb_rvalid_o,
  output logic [31:0] lb_rdata_o,
  input  logic        pci_req_i,
  input  logic        pci_we_i,
  input  logic [5:0]  pci_reg_i,
  input  logic [3:0]  pci_be_i,
  input  logic [31:0] pci_wdata_i,
  output logic        pci_rvalid_o,
  output logic [31:0] pci_rdata_o
);
  cfg_addr_t        cfg_q, cfg_wval;
  logic [DW-1:0]    addr_rdata, lb_dword, pci_dword, lane_wdata, lane_rdata, lb_rd_next;
  logic [LANES-1:0] lane_be;
  logic [NBYTE-1:0] lb_be_all, pci_be_all;
  logic             cfg_open, sel_data, addr_we, lb_data_we, pci_wr;

  assign sel_data   = lb_addr_i[2];
  assign addr_we    = lb_req_i && lb_we_i && !sel_data;
  assign lb_data_we = lb_req_i && lb_we_i && sel_data && cfg_open;
  assign pci_wr     = pci_req_i && pci_we_i;

  assign cfg_wval = '{en: lb_wdata_i[31], bus: lb_wdata_i[23:16], dev: lb_wdata_i[15:11],
                      fn: lb_wdata_i[10:8], reg_no: lb_wdata_i[7:2]};

  pci_cfg_addr_reg u_addr (
    .clk_i, .rst_ni,
    .we_i   (addr_we),
    .wval_i (cfg_wval),
    .addr_o (cfg_q),
    .rdata_o(addr_rdata),
    .open_o (cfg_open)
  );

  pci_cfg_lane u_lane (
    .off_i  (lb_addr_i[1:0]),
    .size_i (lb_size_i),
    .wdata_i(lb_wdata_i),
    .dword_i(lb_dword),
    .be_o   (lane_be),
    .wlane_o(lane_wdata),
    .rdata_o(lane_rdata)
  );

  for (genvar d = 0; d < NREG; d++) begin : g_be
    assign lb_be_all[LANES*d +: LANES] =
      (lb_data_we && cfg_q.reg_no == REG_NO_W'(d)) ? lane_be : '0;
    assign pci_be_all[LANES*d +: LANES] =
      (pci_wr && pci_reg_i == REG_NO_W'(d)) ? pci_be_i : '0;
  end

  pci_cfg_store #(
    .NREG(NREG), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
    .CLASS_CODE(CLASS_CODE), .INT_PIN(INT_PIN), .MIN_GNT(MIN_GNT)
  ) u_store (
    .clk_i, .rst_ni,
    .lb_be_i    (lb_be_all),
    .lb_wdata_i (lane_wdata),
    .pci_be_i   (pci_be_all),
    .pci_wdata_i(pci_wdata_i),
    .lb_idx_i   (cfg_q.reg_no),
    .pci_idx_i  (pci_reg_i),
    .lb_dword_o (lb_dword),
    .pci_dword_o(pci_dword)
  );

  assign lb_rd_next = !sel_data ? addr_rdata : (cfg_open ? lane_rdata : '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lb_rvalid_o  <= 1'b0;
      lb_rdata_o   <= '0;
      pci_rvalid_o <= 1'b0;
      pci_rdata_o  <= '0;
    end else begin
      lb_rvalid_o  <= lb_req_i && !lb_we_i;
      pci_rvalid_o <= pci_req_i && !pci_we_i;
      if (lb_req_i && !lb_we_i)   lb_rdata_o  <= lb_rd_next;
      if (pci_req_i && !pci_we_i) pci_rdata_o <= pci_dword;
    end
  end
endmodule

// File: rtl/pci_cfg_window_chk.sv
module pci_cfg_window_chk #(
  parameter int unsigned NREG = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lb_req_i,
  input logic        lb_we_i,
  input logic [2:0]  lb_addr_i,
  input logic        lb_rvalid_o,
  input logic [31:0] lb_rdata_o,
  input logic        pci_req_i,
  input logic        pci_we_i,
  input logic [5:0]  pci_reg_i,
  input logic        pci_rvalid_o,
  input logic [31:0] pci_rdata_o,
  input logic        cfg_open
);
  assert_lb_rvalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_req_i && !lb_we_i) |=> lb_rvalid_o);

  assert_lb_no_spurious_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lb_req_i && !lb_we_i) |=> !lb_rvalid_o);

  assert_pci_rvalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_req_i && !pci_we_i) |=> pci_rvalid_o);

  assert_addr_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_req_i && !lb_we_i && !lb_addr_i[2]) |=> ((lb_rdata_o & 32'h7F00_0003) == 32'h0));

  assert_closed_reads_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_req_i && !lb_we_i && lb_addr_i[2] && !cfg_open) |=> (lb_rdata_o == 32'hFFFF_FFFF));

  assert_high_reg_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_req_i && !pci_we_i && pci_reg_i >= 6'(NREG)) |=> (pci_rdata_o == 32'h0));
endmodule

bind pci_cfg_window pci_cfg_window_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/pci_cfg_window_tb.sv
module pci_cfg_window_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lb_req_i = 0, lb_we_i = 0;
  logic [2:0]  lb_addr_i = '0;
  logic [1:0]  lb_size_i = '0;
  logic [31:0] lb_wdata_i = '0;
  logic        lb_rvalid_o;
  logic [31:0] lb_rdata_o;
  logic        pci_req_i = 0, pci_we_i = 0;
  logic [5:0]  pci_reg_i = '0;
  logic [3:0]  pci_be_i = '0;
  logic [31:0] pci_wdata_i = '0;
  logic        pci_rvalid_o;
  logic [31:0] pci_rdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] lb_exp_q[$], pci_exp_q[$];
  string       lb_tag_q[$], pci_tag_q[$];

  always #10 clk_i = ~clk_i;

  pci_cfg_window u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: results are due one cycle after the request
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (lb_rvalid_o) begin
        if (lb_exp_q.size() == 0) chk("R11 lb unexpected rvalid", 32'h1, 32'h0);
        else chk(lb_tag_q.pop_front(), lb_rdata_o, lb_exp_q.pop_front());
      end
      if (pci_rvalid_o) begin
        if (pci_exp_q.size() == 0) chk("R11 pci unexpected rvalid", 32'h1, 32'h0);
        else chk(pci_tag_q.pop_front(), pci_rdata_o, pci_exp_q.pop_front());
      end
    end
  end

  task automatic lb_wr(logic [2:0] a, logic [1:0] sz, logic [31:0] d);
    lb_req_i = 1; lb_we_i = 1; lb_addr_i = a; lb_size_i = sz; lb_wdata_i = d;
    @(negedge clk_i);
    lb_req_i = 0; lb_we_i = 0;
  endtask

  task automatic lb_rd(logic [2:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
    lb_exp_q.push_back(exp); lb_tag_q.push_back(tag);
    lb_req_i = 1; lb_we_i = 0; lb_addr_i = a; lb_size_i = sz;
    @(negedge clk_i);
    lb_req_i = 0;
  endtask

  task automatic pci_wr(logic [5:0] r, logic [3:0] be, logic [31:0] d);
    pci_req_i = 1; pci_we_i = 1; pci_reg_i = r; pci_be_i = be; pci_wdata_i = d;
    @(negedge clk_i);
    pci_req_i = 0; pci_we_i = 0;
  endtask

  task automatic pci_rd(logic [5:0] r, logic [31:0] exp, string tag);
    pci_exp_q.push_back(exp); pci_tag_q.push_back(tag);
    pci_req_i = 1; pci_we_i = 0; pci_reg_i = r;
    @(negedge clk_i);
    pci_req_i = 0;
  endtask

  task automatic set_cfg(logic [5:0] r);
    lb_wr(3'b000, 2'd2, 32'h8000_0000 | {24'b0, r, 2'b00});
  endtask

  // both ports write in the same cycle
  task automatic dual_wr(logic [1:0] off, logic [31:0] lbd, logic [5:0] r,
                         logic [3:0] be, logic [31:0] pd);
    lb_req_i = 1; lb_we_i = 1; lb_addr_i = {1'b1, off}; lb_size_i = 2'd0; lb_wdata_i = lbd;
    pci_req_i = 1; pci_we_i = 1; pci_reg_i = r; pci_be_i = be; pci_wdata_i = pd;
    @(negedge clk_i);
    lb_req_i = 0; lb_we_i = 0; pci_req_i = 0; pci_we_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 lb_rvalid in reset", {31'b0, lb_rvalid_o}, 32'h0);
    chk("R1 pci_rvalid in reset", {31'b0, pci_rvalid_o}, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);

    lb_rd(3'b000, 2'd2, 32'h0, "R1 address register reset");
    lb_rd(3'b100, 2'd2, 32'hFFFF_FFFF, "R3 read with enable clear");
    pci_rd(6'd0, 32'h0B17_A5C3, "R1 vendor/device via pci");
    pci_rd(6'd15, 32'h0004_0100, "R1 int pin / min grant defaults");

    // R2 field layout and reserved bits
    lb_wr(3'b000, 2'd0, 32'hFFFF_FFFF);
    lb_rd(3'b011, 2'd0, 32'h80FF_FFFC, "R2 address fields readback");

    // R3 closed window: device nonzero, then enable clear
    lb_wr(3'b000, 2'd2, 32'h8000_0800);
    lb_wr(3'b100, 2'd2, 32'h1234_5678);
    lb_rd(3'b100, 2'd2, 32'hFFFF_FFFF, "R3 nonzero device reads ones");
    lb_wr(3'b000, 2'd2, 32'h0000_0004);
    lb_wr(3'b100, 2'd2, 32'hDEAD_BEEF);
    set_cfg(6'd0);
    lb_rd(3'b100, 2'd2, 32'h0B17_A5C3, "R3 closed write left reg0 intact");
    set_cfg(6'd1);
    lb_rd(3'b100, 2'd2, 32'h0, "R3 closed write left command intact");

    // R4 byte lanes
    set_cfg(6'd2);
    lb_rd(3'b100, 2'd0, 32'h0000_0002, "R4 byte read revision");
    lb_rd(3'b100, 2'd2, 32'h0680_0002, "R1 class code default");
    lb_wr(3'b101, 2'd1, 32'h0000_BEEF);
    lb_rd(3'b100, 2'd2, 32'h06BE_EF02, "R4 half write at offset 1");
    lb_rd(3'b110, 2'd1, 32'h0000_06BE, "R4 half read at offset 2");
    lb_rd(3'b111, 2'd2, 32'h0000_0006, "R4 word read at offset 3 truncated");
    lb_wr(3'b110, 2'd2, 32'h1122_3344);
    lb_rd(3'b100, 2'd2, 32'h3344_EF02, "R5 word write at offset 2 dropped overflow");

    // R7 read-only around latency timer
    set_cfg(6'd3);
    lb_wr(3'b100, 2'd2, 32'hFFFF_FFFF);
    lb_rd(3'b100, 2'd2, 32'h0000_FF00, "R7 read-only bytes hold, latency writable");
    pci_wr(6'd3, 4'hF, 32'h0000_0000);
    pci_rd(6'd3, 32'h0, "R6 pci clears latency timer");
    pci_wr(6'd4, 4'hF, 32'hFFFF_FFFF);
    pci_rd(6'd4, 32'h0, "R7 BAR0 read-only from pci");

    // R6 pci rights
    pci_wr(6'd0, 4'hF, 32'hFFFF_FFFF);
    pci_rd(6'd0, 32'h0B17_A5C3, "R6 pci cannot write vendor/device");
    pci_wr(6'd1, 4'hF, 32'hCAFE_1234);
    pci_rd(6'd1, 32'hCAFE_1234, "R6 pci writes command/status");
    set_cfg(6'd1);
    lb_rd(3'b100, 2'd2, 32'hCAFE_1234, "R6 local sees pci command write");
    pci_wr(6'd11, 4'hF, 32'hFFFF_FFFF);
    pci_rd(6'd11, 32'h0, "R6 pci cannot write subsystem IDs");
    set_cfg(6'd11);
    lb_wr(3'b100, 2'd2, 32'h5566_7788);
    lb_rd(3'b100, 2'd2, 32'h5566_7788, "R5 local writes subsystem IDs");

    // R8 unimplemented
    set_cfg(6'd10);
    lb_wr(3'b100, 2'd2, 32'hFFFF_FFFF);
    lb_rd(3'b100, 2'd2, 32'h0, "R8 CIS pointer reads zero");
    set_cfg(6'd20);
    lb_wr(3'b100, 2'd2, 32'hFFFF_FFFF);
    lb_rd(3'b100, 2'd2, 32'h0, "R8 register 20 reads zero");
    pci_wr(6'd12, 4'hF, 32'hFFFF_FFFF);
    pci_rd(6'd12, 32'h0, "R8 expansion ROM reads zero");

    // R10 collisions
    set_cfg(6'd15);
    dual_wr(2'd0, 32'h0000_00AA, 6'd15, 4'b0001, 32'h0000_0055);
    lb_rd(3'b100, 2'd2, 32'h0004_01AA, "R10 same byte local wins");
    set_cfg(6'd5);
    dual_wr(2'd0, 32'h0000_0011, 6'd5, 4'b0010, 32'h0000_2200);
    pci_rd(6'd5, 32'h0000_2211, "R10 different bytes both land");

    // R9 pci byte enables
    pci_wr(6'd6, 4'b1010, 32'hA1B2_C3D4);
    pci_rd(6'd6, 32'hA100_C300, "R9 pci byte enables");

    repeat (3) @(negedge clk_i);
    chk("R11 lb reads all answered", lb_exp_q.size(), 32'h0);
    chk("R11 pci reads all answered", pci_exp_q.size(), 32'h0);
    finish_run();
  end
endmodule